// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits behind the serial command decoder of a byte-addressed non-volatile memory. It takes the data bytes of a page program command, stores them in a page-sized buffer and decides when the command ends whether the command was framed correctly. If it was, the block runs a self-timed programming cycle into the array. The decoder opens a command with a start pulse that carries the first byte address and the kind of command: a page write to the array or a write of the one-byte status register. Data bytes then arrive over a valid/ready stream. When chip select rises, the decoder reports that event together with the number of serial bits received since the last byte boundary.

The buffer keeps the page number fixed. Only the low offset bits advance, so a long burst wraps inside the page, and a later byte replaces an earlier one at the same offset. A mask bit for each buffer entry records which offsets hold a byte that was accepted and allowed by the protection logic, and only those offsets are programmed. After a commit, a busy flag stays high while a countdown of a parameterised number of clock cycles runs and while the buffer is copied to the array, one offset per clock. A one-cycle completion pulse then tells the write-enable logic to clear its latch.

Back-pressure rules for the byte stream: `in_ready` is high only while a command is being collected and no chip-select rise is reported in that cycle. A byte transfers on a clock edge where both `in_valid` and `in_ready` are high. Whenever `in_ready` is low, the block drops offered bytes. The sender does not need to hold them.

Top module: `page_write_seq`

## Requirements
- R1: A chip-select rise reported with bit phase 0, after at least one allowed data byte of a page write, commits the command. `busy` is high from the next cycle for exactly CYC_CLKS + PAGE_BYTES + 1 cycles.
- R2: Byte k of a page write (k counted from 0) goes to the page of `cmd_addr`, at offset (`cmd_addr[5:0]` + k) mod 64. After offset 63 the next byte goes to offset 0 of the same page.
- R3: When a burst is longer than the page, the last byte accepted for an offset is the one programmed. Each offset is written at most once per cycle, in ascending offset order.
- R4: A chip-select rise reported with a non-zero bit phase cancels the command. No array write takes place, `busy` stays low and no completion pulse occurs.
- R5: A byte accepted with `in_allow` low is not programmed. A command with no allowed byte does not start a cycle when chip select rises.
- R6: Only offsets that received an allowed byte in the current command are written. All other array locations keep their contents.
- R7: A status write commits only when exactly one allowed byte was received and the bit phase is 0. `sr_we` then pulses once with that byte in `sr_wdata`, and `busy` lasts CYC_CLKS + 1 cycles. Two or more bytes, or a non-zero phase, cancel it.
- R8: `done` is a single-cycle pulse in the last busy cycle, and `busy` is low in the cycle after it.
- R9: While `busy` is high, `in_ready` is low and `cmd_start` is ignored. No command opens during the cycle and the cycle's writes are unchanged.
- R10: After reset, `busy`, `done`, `in_ready`, `arr_we` and `sr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a command (accepted only when idle) |
| cmd_is_status | input | 1 | 1: status register write, 0: page write |
| cmd_addr | input | AW | Start byte address |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Data byte can be taken |
| in_data | input | 8 | Data byte |
| in_allow | input | 1 | Protection verdict for this byte (1 = may be written) |
| cs_rise | input | 1 | Chip select rose this cycle |
| bit_phase | input | 3 | Bits received since the last byte boundary |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 8 | Status register write data |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | Completion pulse, clears the write-enable latch |

## Verification
On every cycle, the embedded assertions check that array writes happen only while busy, that consecutive writes stay in one page, that the stream is never ready while busy, that the countdown is not cut short, that an allowed byte sets its mask bit, and that the completion pulse ends the busy period. The directed scenarios are needed to show the committed data: wrapped and overwritten offsets, the exact busy length, cancellation on a misaligned rise, the effect of denied bytes, and the status-register framing rule.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_PROG,
    ST_COPY,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/pws_collect.sv
module pws_collect #(
  parameter int PAGE_BYTES = 64,
  localparam int OFFW = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [OFFW-1:0] base_off,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            wr_allow,
  input  logic [OFFW-1:0] rd_off,
  output logic [7:0]      rd_data,
  output logic            rd_mask,
  output logic            any_mask,
  output logic [1:0]      nbytes,
  output logic [7:0]      last_byte
);
  logic [OFFW-1:0]       ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            data_q [PAGE_BYTES];
  logic [1:0]            cnt_q;
  logic [7:0]            last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (clear) begin
      ptr_q  <= base_off;
      cnt_q  <= '0;
    end else if (wr_en) begin
      ptr_q  <= ptr_q + 1'b1;
      last_q <= wr_data;
      if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g]  <= 1'b0;
        data_q[g]  <= '0;
      end else if (clear) begin
        mask_q[g]  <= 1'b0;
      end else if (wr_en && ptr_q == OFFW'(g)) begin
        data_q[g]  <= wr_data;
        mask_q[g]  <= wr_allow;
      end
    end
  end

  assign rd_data   = data_q[rd_off];
  assign rd_mask   = mask_q[rd_off];
  assign any_mask  = |mask_q;
  assign nbytes    = cnt_q;
  assign last_byte = last_q;

  AST_ALLOWED_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_allow && !clear) |=> mask_q[$past(ptr_q)]); // R6
  AST_DENIED_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_allow && !clear) |=> !mask_q[$past(ptr_q)]); // R5
endmodule

// File: rtl/pws_timer.sv
module pws_timer #(
  parameter int CYC_CLKS = 100000,
  localparam int CW = $clog2(CYC_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CW'(CYC_CLKS - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

  AST_TIMER_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !load) |=> (run_q && !expired) || (cnt_q == '0)); // R1
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int AW         = 14,
  parameter int PAGE_BYTES = 64,
  parameter int CYC_CLKS   = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_is_status,
  input  logic [AW-1:0] cmd_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_allow,
  input  logic          cs_rise,
  input  logic [2:0]    bit_phase,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          sr_we,
  output logic [7:0]    sr_wdata,
  output logic          busy,
  output logic          done
);
  import pws_pkg::*;

  localparam int OFFW = $clog2(PAGE_BYTES);
  localparam int PW   = AW - OFFW;

  seq_state_e      st_q;
  logic [PW-1:0]   page_q;
  logic            stat_q;
  logic [OFFW-1:0] off_q;

  logic            accept, take, commit, expired;
  logic [7:0]      rd_data, last_byte;
  logic            rd_mask, any_mask;
  logic [1:0]      nbytes;

  assign accept   = (st_q == ST_IDLE) && cmd_start;
  assign in_ready = (st_q == ST_COLLECT) && !cs_rise;
  assign take     = in_valid && in_ready;
  assign commit   = (st_q == ST_COLLECT) && cs_rise && (bit_phase == 3'd0) &&
                    any_mask && (!stat_q || nbytes == 2'd1);

  pws_collect #(.PAGE_BYTES(PAGE_BYTES)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .base_off (cmd_addr[OFFW-1:0]),
    .wr_en    (take),
    .wr_data  (in_data),
    .wr_allow (in_allow),
    .rd_off   (off_q),
    .rd_data  (rd_data),
    .rd_mask  (rd_mask),
    .any_mask (any_mask),
    .nbytes   (nbytes),
    .last_byte(last_byte)
  );

  pws_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (commit),
    .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      stat_q <= 1'b0;
      off_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_COLLECT;
          page_q <= cmd_addr[AW-1:OFFW];
          stat_q <= cmd_is_status;
        end
        ST_COLLECT: if (cs_rise) begin
          st_q  <= commit ? ST_PROG : ST_IDLE;
          off_q <= '0;
        end
        ST_PROG: if (expired) st_q <= stat_q ? ST_FIN : ST_COPY;
        ST_COPY: begin
          off_q <= off_q + 1'b1;
          if (off_q == OFFW'(PAGE_BYTES - 1)) st_q <= ST_FIN;
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q == ST_PROG) || (st_q == ST_COPY) || (st_q == ST_FIN);
  assign done      = (st_q == ST_FIN);
  assign arr_we    = (st_q == ST_COPY) && rd_mask;
  assign arr_addr  = {page_q, off_q};
  assign arr_wdata = rd_data;
  assign sr_we     = (st_q == ST_FIN) && stat_q;
  assign sr_wdata  = last_byte;

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || sr_we) |-> busy); // R4
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> arr_addr[AW-1:OFFW] == $past(arr_addr[AW-1:OFFW])); // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done)); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R1
endmodule

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;
  localparam int AW = 14;
  localparam int PB = 64;
  localparam int CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_is_status = 0, in_valid = 0, in_allow = 1, cs_rise = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] in_data = '0;
  logic [2:0] bit_phase = '0;
  logic in_ready, arr_we, sr_we, busy, done;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, sr_wdata;

  int errors = 0, checks = 0, nwrites = 0, nsr = 0;
  logic [7:0] sr_last = '0;
  logic [7:0] mem [int];
  bit finished = 0;

  always #10 clk = ~clk;

  page_write_seq #(.AW(AW), .PAGE_BYTES(PB), .CYC_CLKS(CYC)) u0 (
    .clk, .rst_n, .cmd_start, .cmd_is_status, .cmd_addr, .in_valid, .in_ready,
    .in_data, .in_allow, .cs_rise, .bit_phase, .arr_we, .arr_addr, .arr_wdata,
    .sr_we, .sr_wdata, .busy, .done);

  always @(negedge clk) begin
    if (arr_we) begin mem[int'(arr_addr)] = arr_wdata; nwrites++; end
    if (sr_we) begin sr_last = sr_wdata; nsr++; end
  end

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_cmd(logic st, logic [AW-1:0] a);
    @(negedge clk); cmd_start = 1; cmd_is_status = st; cmd_addr = a;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic send(logic [7:0] d, logic al);
    in_valid = 1; in_data = d; in_allow = al;
    @(negedge clk); in_valid = 0; in_allow = 1;
  endtask

  task automatic end_cmd(logic [2:0] ph);
    cs_rise = 1; bit_phase = ph;
    @(negedge clk); cs_rise = 0; bit_phase = 0;
  endtask

  // counts busy cycles from current negedge; returns done pulses seen
  task automatic wait_busy(output int cyc, output int dones, output int last_done);
    cyc = 0; dones = 0; last_done = 0;
    while (busy && cyc < 1000) begin
      cyc++; last_done = done; if (done) dones++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 in_ready", in_ready, 0); chk("R10 arr_we", arr_we, 0);
    chk("R10 sr_we", sr_we, 0);
  endtask

  task automatic t_single;
    int c, d, l, w0;
    w0 = nwrites;
    open_cmd(0, 14'h0105);
    chk("R9 ready when collecting", in_ready, 1);
    send(8'h5A, 1);
    end_cmd(0);
    chk("R1 busy after commit", busy, 1);
    wait_busy(c, d, l);
    chk("R1 busy length", c, CYC + PB + 1);
    chk("R8 one done pulse", d, 1); chk("R8 done in last busy cycle", l, 1);
    chk("R2 data at start addr", rd(14'h0105), 8'h5A);
    chk("R6 single write", nwrites - w0, 1);
  endtask

  task automatic t_wrap;
    int c, d, l, w0;
    w0 = nwrites;
    open_cmd(0, 14'h00FE);
    for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 1);
    end_cmd(0);
    wait_busy(c, d, l);
    chk("R2 off 3E", rd(14'h00FE), 8'h10);
    chk("R2 off 3F", rd(14'h00FF), 8'h11);
    chk("R2 wrap off 00", rd(14'h00C0), 8'h12);
    chk("R2 wrap off 01", rd(14'h00C1), 8'h13);
    chk("R2 next page untouched", rd(14'h0100), 8'hFF);
    chk("R6 write count", nwrites - w0, 4);
  endtask

  task automatic t_overwrite;
    int c, d, l, w0, bad;
    logic [7:0] exp [PB];
    w0 = nwrites; bad = 0;
    open_cmd(0, 14'h013F);
    for (int i = 0; i < 66; i++) begin
      send(8'(i + 1), 1);
      exp[(63 + i) % PB] = 8'(i + 1);
    end
    end_cmd(0);
    wait_busy(c, d, l);
    for (int k = 0; k < PB; k++) if (rd(14'h0100 + k) != exp[k]) bad++;
    chk("R3 page contents after overwrite", bad, 0);
    chk("R3 each offset once", nwrites - w0, PB);
  endtask

  task automatic t_cancel;
    int w0;
    w0 = nwrites;
    open_cmd(0, 14'h0200);
    send(8'hAA, 1); send(8'hBB, 1);
    end_cmd(3);
    chk("R4 no busy", busy, 0);
    repeat (CYC + PB + 4) @(negedge clk);
    chk("R4 no writes", nwrites - w0, 0);
    chk("R4 location kept", rd(14'h0200), 8'hFF);
  endtask

  task automatic t_allow;
    int c, d, l, w0;
    w0 = nwrites;
    open_cmd(0, 14'h0300);
    send(8'h01, 1); send(8'h02, 0); send(8'h03, 1);
    end_cmd(0);
    wait_busy(c, d, l);
    chk("R5 denied byte not written", rd(14'h0301), 8'hFF);
    chk("R5 allowed byte written", rd(14'h0302), 8'h03);
    chk("R6 write count", nwrites - w0, 2);
    open_cmd(0, 14'h0310);
    send(8'h44, 0);
    end_cmd(0);
    chk("R5 no cycle when all denied", busy, 0);
    repeat (3) @(negedge clk);
    chk("R5 denied only location", rd(14'h0310), 8'hFF);
  endtask

  task automatic t_busy_ignore;
    int c, d, l, w0;
    w0 = nwrites;
    open_cmd(0, 14'h0400);
    send(8'h77, 1);
    end_cmd(0);
    cmd_start = 1; cmd_addr = 14'h0500; in_valid = 1; in_data = 8'hEE;
    repeat (3) begin chk("R9 not ready while busy", in_ready, 0); @(negedge clk); end
    cmd_start = 0; in_valid = 0;
    wait_busy(c, d, l);
    chk("R9 no command opened", in_ready, 0);
    chk("R9 writes unchanged", nwrites - w0, 1);
    chk("R9 programmed byte", rd(14'h0400), 8'h77);
    chk("R9 ignored address", rd(14'h0500), 8'hFF);
  endtask

  task automatic t_status;
    int c, d, l, n0, w0;
    n0 = nsr; w0 = nwrites;
    open_cmd(1, '0);
    send(8'h8C, 1);
    end_cmd(0);
    wait_busy(c, d, l);
    chk("R7 status busy length", c, CYC + 1);
    chk("R7 one status write", nsr - n0, 1);
    chk("R7 status data", sr_last, 8'h8C);
    chk("R7 no array write", nwrites - w0, 0);
    open_cmd(1, '0);
    send(8'h11, 1); send(8'h22, 1);
    end_cmd(0);
    chk("R7 two bytes cancel", busy, 0);
    open_cmd(1, '0);
    send(8'h33, 1);
    end_cmd(1);
    chk("R7 misaligned cancel", busy, 0);
    repeat (CYC + 4) @(negedge clk);
    chk("R7 no further status write", nsr - n0, 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overwrite();
    t_cancel();
    t_allow();
    t_busy_ignore();
    t_status();
    summary();
  end
endmodule